// File: doc/BRIEF.md
# Packed Depth/Stencil Word Access Unit

This block owns a small word memory holding 32-bit surface words. Each word is either a packed depth/stencil pair (24-bit depth and 8-bit stencil) or a colour pixel. A requester asks for one operation at a time: read or update the depth field alone, read or update the stencil field alone, read or write the whole depth/stencil pair, or read a colour pixel with or without its alpha channel.

Packed words can use one of two byte orders, chosen per request by a layout bit. In the depth-high layout the depth sits in bits 31:8 and the stencil in bits 7:0. In the stencil-high layout the stencil sits in bits 31:24 and the depth in bits 23:0. Field updates are read-modify-write, so the other field survives. Whole-pair accesses always use the depth-high order at the port and are rotated by one byte when the memory uses the stencil-high layout.

A state machine walks each request through the states IDLE, FETCH, MERGE and WRITE. In IDLE an accepted request is captured (IDLE to FETCH). FETCH reads the word (FETCH to MERGE). MERGE either returns read data (MERGE to IDLE) or forms the updated word (MERGE to WRITE). WRITE stores the word and reports completion (WRITE to IDLE).

Top module: `zs_pack_unit`

## Requirements
- R1: A synchronous reset returns the unit to IDLE with `req_ready` high and `rsp_valid` low. Reset does not change the stored words.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low while the request is in progress. Opcodes are: 0 depth read, 1 depth write, 2 stencil read, 3 stencil write, 4 pair read, 5 pair write, 6 colour read without alpha, 7 colour read with alpha. `rsp_valid` is a one-cycle pulse. It is seen two edges after the accepting edge for reads and three edges after it for writes. A write returns the stored word on `rsp_data`.
- R3: With `req_layout`=0 (depth high), a depth write puts `req_wdata[23:0]` into bits 31:8 and keeps bits 7:0. A depth read returns bits 31:8 zero-extended.
- R4: With `req_layout`=1 (stencil high), a depth write puts `req_wdata[23:0]` into bits 23:0 and keeps bits 31:24. A depth read returns bits 23:0 zero-extended.
- R5: A stencil write puts `req_wdata[7:0]` into bits 7:0 (layout 0) or bits 31:24 (layout 1) and keeps the rest. A stencil read returns that byte zero-extended.
- R6: With layout 0, a pair write stores `req_wdata` unchanged and a pair read returns the stored word unchanged.
- R7: With layout 1, a pair write stores `{wdata[7:0], wdata[31:8]}`. A pair read returns `{word[23:0], word[31:24]}`.
- R8: A colour read without alpha returns the word with bits 31:24 forced to 0xFF. A colour read with alpha returns the word unchanged. Both ignore `req_layout`.
- R9: A depth write followed directly by a stencil write to the same word keeps both new fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write value |
| req_layout | input | 1 | 0 depth high, 1 stencil high |
| rsp_valid | output | 1 | Completion pulse |
| rsp_data | output | 32 | Read result or stored word |

## Verification
The assertions assume that `req_op` is stable and meaningful whenever `req_valid` is high. They also assume that a request is never withdrawn in the same cycle it would be taken. The bench drives a request only at the falling edge, only after it sees `req_ready` high, and drops `req_valid` right after the accepting edge. Reset is applied only while the unit is idle, so the latency properties are never cut off by a reset in the middle of a request.

// File: rtl/zs_pack_pkg.sv
package zs_pack_pkg;
    localparam int WORD_W = 32;
    localparam int Z_W    = 24;
    localparam int S_W    = WORD_W - Z_W;

    typedef enum logic [2:0] {
        OP_RD_Z    = 3'd0,
        OP_WR_Z    = 3'd1,
        OP_RD_S    = 3'd2,
        OP_WR_S    = 3'd3,
        OP_RD_ZS   = 3'd4,
        OP_WR_ZS   = 3'd5,
        OP_RD_RGBX = 3'd6,
        OP_RD_RGBA = 3'd7
    } zs_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_MERGE = 2'd2,
        ST_WRITE = 2'd3
    } zs_state_e;

    function automatic logic op_writes(zs_op_e op);
        return (op == OP_WR_Z) || (op == OP_WR_S) || (op == OP_WR_ZS);
    endfunction
endpackage

// File: rtl/zs_word_mem.sv
module zs_word_mem #(
    parameter int ADDR_W = 4,
    parameter int W      = 32
) (
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= store_q[rd_addr];
    end
endmodule

// File: rtl/zs_lane.sv
module zs_lane
    import zs_pack_pkg::*;
(
    input  zs_op_e            op,
    input  logic              layout,
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] new_word,
    output logic [WORD_W-1:0] rd_value
);
    logic [Z_W-1:0] z_old;
    logic [S_W-1:0] s_old;

    always_comb begin
        if (layout) begin
            z_old = old_word[Z_W-1:0];
            s_old = old_word[WORD_W-1:Z_W];
        end else begin
            z_old = old_word[WORD_W-1:S_W];
            s_old = old_word[S_W-1:0];
        end
    end

    always_comb begin
        new_word = old_word;
        rd_value = old_word;
        unique case (op)
            OP_RD_Z:    rd_value = {{S_W{1'b0}}, z_old};
            OP_RD_S:    rd_value = {{Z_W{1'b0}}, s_old};
            OP_WR_Z:    new_word = layout ? {s_old, wdata[Z_W-1:0]}
                                          : {wdata[Z_W-1:0], s_old};
            OP_WR_S:    new_word = layout ? {wdata[S_W-1:0], z_old}
                                          : {z_old, wdata[S_W-1:0]};
            OP_RD_ZS:   rd_value = {z_old, s_old};
            OP_WR_ZS:   new_word = layout ? {wdata[S_W-1:0], wdata[WORD_W-1:S_W]}
                                          : wdata;
            OP_RD_RGBX: rd_value = {{S_W{1'b1}}, old_word[Z_W-1:0]};
            OP_RD_RGBA: rd_value = old_word;
        endcase
    end
endmodule

// File: rtl/zs_pack_unit.sv
module zs_pack_unit
    import zs_pack_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              req_layout,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);
    zs_state_e         state_q, state_d;
    zs_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] wdata_q;
    logic              layout_q;
    logic [WORD_W-1:0] mem_rd;
    logic [WORD_W-1:0] merged_q;
    logic [WORD_W-1:0] lane_new;
    logic [WORD_W-1:0] lane_rd;
    logic              accept;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    zs_word_mem #(.ADDR_W(ADDR_W), .W(WORD_W)) u_mem (
        .clk     (clk),
        .rd_en   (state_q == ST_FETCH),
        .rd_addr (addr_q),
        .rd_data (mem_rd),
        .wr_en   (state_q == ST_WRITE),
        .wr_addr (addr_q),
        .wr_data (merged_q)
    );

    zs_lane u_lane (
        .op       (op_q),
        .layout   (layout_q),
        .old_word (mem_rd),
        .wdata    (wdata_q),
        .new_word (lane_new),
        .rd_value (lane_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_MERGE;
            ST_MERGE: state_d = op_writes(op_q) ? ST_WRITE : ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    op_q     <= zs_op_e'(req_op);
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    layout_q <= req_layout;
                end
                ST_FETCH: ;
                ST_MERGE: begin
                    if (op_writes(op_q)) begin
                        merged_q <= lane_new;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= lane_rd;
                    end
                end
                ST_WRITE: begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= merged_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/zs_pack_unit_chk.sv
module zs_pack_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [2:0]  req_op,
    input logic        rsp_valid,
    input logic [31:8] rsp_hi
);
    logic acc, acc_wr;
    assign acc    = req_valid && req_ready;
    assign acc_wr = acc && (req_op == 3'd1 || req_op == 3'd3 || req_op == 3'd5);

    // R2
    hold_off_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> !req_ready);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R2
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !acc_wr) |=> !rsp_valid ##1 !rsp_valid ##1 rsp_valid);

    // R2
    write_lat_chk: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !rsp_valid ##1 !rsp_valid ##1 !rsp_valid ##1 rsp_valid);

    // R8
    alpha_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd6) |=> ##2 (rsp_hi[31:24] == 8'hFF));

    // R5
    sten_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd2) |=> ##2 (rsp_hi == 24'h0));

    // R3
    depth_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_op == 3'd0) |=> ##2 (rsp_hi[31:24] == 8'h0));
endmodule

bind zs_pack_unit zs_pack_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_hi    (rsp_data[31:8])
);

// File: tb/zs_pack_unit_tb.sv
`timescale 1ns/1ps
module zs_pack_unit_tb;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = 3'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          req_layout = 1'b0;
    logic          rsp_valid;
    logic [31:0]   rsp_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [31:0] q_data [$];
    int          q_cyc  [$];
    string       q_req  [$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    zs_pack_unit #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_layout(req_layout), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: issue one request and queue its expected completion
    task automatic do_op(input logic [2:0] op, input logic [AW-1:0] addr,
                         input logic [31:0] wd, input logic lay,
                         input logic [31:0] exp, input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_wdata = wd;   req_layout = lay;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 ready low while busy", {31'd0, req_ready}, 32'd0);
        q_data.push_back(exp);
        q_cyc.push_back(cyc + ((op == 3'd1 || op == 3'd3 || op == 3'd5) ? 3 : 2));
        q_req.push_back(req);
    endtask

    // monitor: compare each completion against the queue head
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R2 unexpected completion", rsp_data, 32'd0);
            end else begin
                logic [31:0] e;
                int          c;
                string       r;
                e = q_data.pop_front();
                c = q_cyc.pop_front();
                r = q_req.pop_front();
                check(rsp_data === e, r, rsp_data, e);
                check(cyc == c, "R2 completion latency", cyc, c);
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready === 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid === 1'b0, "R1 no done after reset", {31'd0, rsp_valid}, 32'd0);

        // R6 depth-high pair access
        do_op(3'd5, 4'd1, 32'h12345678, 1'b0, 32'h12345678, "R6 pair write A");
        do_op(3'd4, 4'd1, 32'h0,        1'b0, 32'h12345678, "R6 pair read A");
        // R3 depth read, R5 stencil read in layout A
        do_op(3'd0, 4'd1, 32'h0, 1'b0, 32'h00123456, "R3 depth read A");
        do_op(3'd2, 4'd1, 32'h0, 1'b0, 32'h00000078, "R5 stencil read A");
        // R3 depth write keeps stencil; R9 back-to-back stencil write keeps depth
        do_op(3'd1, 4'd1, 32'hAAABCDEF, 1'b0, 32'hABCDEF78, "R3 depth write A");
        do_op(3'd3, 4'd1, 32'h12345699, 1'b0, 32'hABCDEF99, "R9 stencil after depth A");
        do_op(3'd4, 4'd1, 32'h0,        1'b0, 32'hABCDEF99, "R9 both fields kept A");

        // R7 stencil-high pair access rotates
        do_op(3'd5, 4'd2, 32'h11223344, 1'b1, 32'h44112233, "R7 pair write B");
        do_op(3'd4, 4'd2, 32'h0,        1'b1, 32'h11223344, "R7 pair read B");
        do_op(3'd4, 4'd2, 32'h0,        1'b0, 32'h44112233, "R7 raw stored word");
        // R4 depth in layout B, R5 stencil in layout B
        do_op(3'd0, 4'd2, 32'h0, 1'b1, 32'h00112233, "R4 depth read B");
        do_op(3'd2, 4'd2, 32'h0, 1'b1, 32'h00000044, "R5 stencil read B");
        do_op(3'd1, 4'd2, 32'hFF0A0B0C, 1'b1, 32'h440A0B0C, "R4 depth write B");
        do_op(3'd3, 4'd2, 32'h000000E5, 1'b1, 32'hE50A0B0C, "R9 stencil after depth B");
        do_op(3'd0, 4'd2, 32'h0,        1'b1, 32'h000A0B0C, "R9 depth kept B");
        do_op(3'd2, 4'd2, 32'h0,        1'b1, 32'h000000E5, "R5 stencil kept B");

        // R8 colour reads
        do_op(3'd5, 4'd3, 32'h55667788, 1'b0, 32'h55667788, "R8 colour setup");
        do_op(3'd6, 4'd3, 32'h0, 1'b0, 32'hFF667788, "R8 colour no alpha");
        do_op(3'd7, 4'd3, 32'h0, 1'b0, 32'h55667788, "R8 colour with alpha");
        do_op(3'd6, 4'd3, 32'h0, 1'b1, 32'hFF667788, "R8 layout ignored");

        // R1 reset keeps memory
        @(negedge clk);
        while (!req_ready || q_data.size() != 0) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R1 ready after second reset", {31'd0, req_ready}, 32'd1);
        check(rsp_valid === 1'b0, "R1 idle after second reset", {31'd0, rsp_valid}, 32'd0);
        do_op(3'd4, 4'd1, 32'h0, 1'b0, 32'hABCDEF99, "R1 memory survives reset");

        repeat (6) @(negedge clk);
        check(q_data.size() == 0, "R2 all completions seen", q_data.size(), 32'd0);
        finish_run();
    end
endmodule